// File: doc/BRIEF.md
# Paged PMBus Command Register Decoder

This block is the register file of a power-management bus target that serves many channels through one command space. It keeps a current page number and a current command code. Every access is decoded against the pair: the page picks the channel entry, and the command picks which kind of storage is used. Pages 0 to 15 are monitored voltage/current channels, and the first 12 of them are also sequenced and margined supplies. Pages 16 to 20 are temperature sensors, and page 255 stands for all pages at once.

The bus layer below it has already framed the traffic into bytes. It hands over each received write byte, a strobe for each read byte wanted, and a strobe when it sees a stop condition. The first byte of a write is the command code. Any further bytes are payload, least significant byte first, and they are committed at the stop condition. Read bytes come back the same way. A command/page pair with no storage behind it reads as 0xFF and raises a sticky unsupported flag. A data write to a read-only command is recorded in the communication status registers.

Top module: `pmbus_page_regs`

## Requirements
- R1: After reset the page is 0, OPERATION (0x01) reads 0x80 on every page 0..20, the turn-on maximum fault limit (0x62) reads 0xFFFF, channel configuration (0xD0) reads 0x0020, the voltage minimum (0xD3) reads 0x7FFF, the unsupported flag is low and STATUS_CML (0x7E) reads 0x00.
- R2: The first write byte after a stop latches the command code. A value is stored only when the stop arrives after exactly 1 + length bytes, with payload least significant byte first (length 1 for 0x00, 0x01, 0x7E; 2 for word commands; 4 for 0xD8 and 0xDB). Any other count leaves the stored value unchanged.
- R3: Turn-on delay (0x60), turn-on maximum fault limit (0x62) and sequencing configuration (0xD8, 32 bit) read and write only when page < 12.
- R4: Power-good-on threshold (0x5E), voltage minimum (0xD3) and channel configuration (0xD0) read and write only when page < 16. Average current (0xDA) is read-only and reads 0x0000 when page < 16.
- R5: Temperature peak (0xD5) writes only on pages 16..20, into entry page-16. A read on any page outside 16..20 returns entry 0 and is not flagged.
- R6: A write carrying data to a read-only command (0xDA, 0xDB fault log, 0xDC firmware revision) sets bit 6 of STATUS_CML and bit 1 of STATUS_WORD (0x79). It leaves stored data unchanged and does not raise the unsupported flag.
- R7: Firmware revision (0xDC) reads 0x0001 only when page is 255.
- R8: Every byte read from an illegal command/page pair, or from an unknown code, is 0xFF and sets the unsupported flag. A data write to such a pair also sets the flag. Bytes read past a legal command's length are 0xFF and do not set the flag.
- R9: A legal OPERATION write on page 255 updates all 21 pages, and on page 0..20 it updates only that page. An OPERATION read on page 255 is illegal.
- R10: The unsupported flag and STATUS_CML stay set until CLEAR_FAULTS (0x03) is sent as a lone command byte followed by a stop, which clears both.
- R11: A read strobe updates the read byte and raises the read-valid output on the next clock. Without a strobe the read byte holds and read-valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | A received write byte is present on wrByte |
| wrByte | input | 8 | Received write byte |
| stopSeen | input | 1 | Stop condition seen; ends the transaction |
| rdReq | input | 1 | Request for the next read byte |
| rdByte | output | 8 | Read byte, updated one clock after rdReq |
| rdValid | output | 1 | rdByte was updated on this clock |
| unsupFlag | output | 1 | Sticky unsupported command/page access flag |

## Verification
A wrong page window or a wrong entry index shows up at the ports as a value read back from the wrong place. It can be a stored value where 0xFF was due, 0xFF where data was due, or the wrong channel's data. The flag or status bit also moves against expectation. Each such fault becomes visible on the read that follows the write in the same iteration, a few dozen clocks later. A fault in byte counting or commit timing shows up as a stored value that differs from the one written, and a fault in the sticky flags shows up when the flag is compared after every transaction.

// File: rtl/pgreg_pkg.sv
package pgreg_pkg;

  typedef enum logic [7:0] {
    CMD_PAGE     = 8'h00,
    CMD_OPER     = 8'h01,
    CMD_CLEAR    = 8'h03,
    CMD_PG_ON    = 8'h5E,
    CMD_TON_DLY  = 8'h60,
    CMD_TON_MAX  = 8'h62,
    CMD_STAT_WRD = 8'h79,
    CMD_STAT_CML = 8'h7E,
    CMD_CH_CFG   = 8'hD0,
    CMD_V_MIN    = 8'hD3,
    CMD_T_PEAK   = 8'hD5,
    CMD_SEQ_CFG  = 8'hD8,
    CMD_I_AVG    = 8'hDA,
    CMD_FLT_LOG  = 8'hDB,
    CMD_FW_REV   = 8'hDC
  } pgreg_cmd_e;

  localparam logic [7:0] PAGE_ALL = 8'hFF;

  // strobes from control to datapath
  typedef struct packed {
    logic       commit;    // store wrData into the addressed entry
    logic       setCml;    // data written to a read-only command
    logic       setUnsup;  // illegal command/page access
    logic       clearAll;  // clear sticky status
    logic       rdStrobe;  // produce a read byte
    logic       rdOk;      // read byte comes from storage
    logic [1:0] rdIdx;     // byte lane of the read word
  } pgreg_strobe_t;

  // payload length in bytes of each command, 0 for none
  function automatic logic [2:0] cmdLen(input logic [7:0] code);
    case (code)
      CMD_PAGE, CMD_OPER, CMD_STAT_CML:                        cmdLen = 3'd1;
      CMD_PG_ON, CMD_TON_DLY, CMD_TON_MAX, CMD_STAT_WRD,
      CMD_CH_CFG, CMD_V_MIN, CMD_T_PEAK, CMD_I_AVG, CMD_FW_REV: cmdLen = 3'd2;
      CMD_SEQ_CFG, CMD_FLT_LOG:                                 cmdLen = 3'd4;
      default:                                                  cmdLen = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/pgreg_ctrl.sv
module pgreg_ctrl
  import pgreg_pkg::*;
#(
  parameter int NUM_MARG = 12,
  parameter int NUM_MON  = 16,
  parameter int NUM_TEMP = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrValid,
  input  logic [7:0]    wrByte,
  input  logic          stopSeen,
  input  logic          rdReq,
  input  logic [7:0]    curPage,
  output logic [7:0]    curCode,
  output logic [31:0]   wrData,
  output pgreg_strobe_t strb
);
  localparam int NUM_PAGES = NUM_MON + NUM_TEMP;
  localparam int MAX_DATA  = 4;

  logic [2:0] wrCnt;
  logic [2:0] rdCnt;
  logic [2:0] lenB;
  logic       inMarg, inMon, inTemp, inAny, isAll;
  logic       wrLegal, rdLegal, roCmd, hasData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrCnt   <= '0;
      rdCnt   <= '0;
      curCode <= '0;
      wrData  <= '0;
    end else if (stopSeen) begin
      wrCnt <= '0;
      rdCnt <= '0;
    end else begin
      if (wrValid) begin
        if (wrCnt == 3'd0) curCode <= wrByte;
        for (int k = 0; k < MAX_DATA; k++) begin
          if (wrCnt == 3'(k + 1)) wrData[8*k +: 8] <= wrByte;
        end
        if (wrCnt != 3'd7) wrCnt <= wrCnt + 3'd1;
        rdCnt <= '0;
      end else if (rdReq && rdCnt != 3'd7) begin
        rdCnt <= rdCnt + 3'd1;
      end
    end
  end

  always_comb begin
    lenB   = cmdLen(curCode);
    inMarg = curPage < 8'(NUM_MARG);
    inMon  = curPage < 8'(NUM_MON);
    inAny  = curPage < 8'(NUM_PAGES);
    inTemp = inAny && !inMon;
    isAll  = curPage == PAGE_ALL;

    case (curCode)
      CMD_PAGE:                              wrLegal = 1'b1;
      CMD_OPER:                              wrLegal = inAny || isAll;
      CMD_TON_DLY, CMD_TON_MAX, CMD_SEQ_CFG: wrLegal = inMarg;
      CMD_PG_ON, CMD_V_MIN, CMD_CH_CFG:      wrLegal = inMon;
      CMD_T_PEAK:                            wrLegal = inTemp;
      default:                               wrLegal = 1'b0;
    endcase

    case (curCode)
      CMD_PAGE, CMD_STAT_WRD, CMD_STAT_CML,
      CMD_FLT_LOG, CMD_T_PEAK:               rdLegal = 1'b1;
      CMD_OPER:                              rdLegal = inAny;
      CMD_TON_DLY, CMD_TON_MAX, CMD_SEQ_CFG: rdLegal = inMarg;
      CMD_PG_ON, CMD_V_MIN, CMD_CH_CFG,
      CMD_I_AVG:                             rdLegal = inMon;
      CMD_FW_REV:                            rdLegal = isAll;
      default:                               rdLegal = 1'b0;
    endcase

    case (curCode)
      CMD_I_AVG, CMD_FLT_LOG, CMD_FW_REV: roCmd = 1'b1;
      default:                            roCmd = 1'b0;
    endcase

    hasData = wrCnt >= 3'd2;

    strb.commit   = stopSeen && wrLegal && (wrCnt == lenB + 3'd1);
    strb.setCml   = stopSeen && hasData && roCmd;
    strb.setUnsup = (stopSeen && hasData && !roCmd && !wrLegal) ||
                    (rdReq && !stopSeen && !rdLegal);
    strb.clearAll = stopSeen && (wrCnt == 3'd1) && (curCode == CMD_CLEAR);
    strb.rdStrobe = rdReq && !stopSeen;
    strb.rdOk     = rdLegal && (rdCnt < lenB);
    strb.rdIdx    = rdCnt[1:0];
  end

endmodule

// File: rtl/pgreg_data.sv
module pgreg_data
  import pgreg_pkg::*;
#(
  parameter int NUM_MARG = 12,
  parameter int NUM_MON  = 16,
  parameter int NUM_TEMP = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  pgreg_strobe_t strb,
  input  logic [7:0]    curCode,
  input  logic [31:0]   wrData,
  output logic [7:0]    curPage,
  output logic [7:0]    rdByte,
  output logic          rdValid,
  output logic          unsupFlag
);
  localparam int          NUM_PAGES   = NUM_MON + NUM_TEMP;
  localparam logic [15:0] TON_MAX_RST = 16'hFFFF;
  localparam logic [15:0] CH_CFG_RST  = 16'h0020;
  localparam logic [15:0] V_MIN_RST   = 16'h7FFF;
  localparam logic [7:0]  OPER_RST    = 8'h80;

  logic [15:0] tonDly [NUM_MARG];
  logic [15:0] tonMax [NUM_MARG];
  logic [31:0] seqCfg [NUM_MARG];
  logic [15:0] pgOn   [NUM_MON];
  logic [15:0] vMin   [NUM_MON];
  logic [15:0] chCfg  [NUM_MON];
  logic [15:0] tPeak  [NUM_TEMP];
  logic [7:0]  oper   [NUM_PAGES];
  logic [7:0]  cmlStat;
  logic [31:0] rdWord;
  logic        tempHit;

  // page, sticky status
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPage   <= '0;
      cmlStat   <= '0;
      unsupFlag <= 1'b0;
    end else begin
      if (strb.commit && curCode == CMD_PAGE) curPage <= wrData[7:0];
      if (strb.clearAll) begin
        cmlStat   <= '0;
        unsupFlag <= 1'b0;
      end
      if (strb.setCml)   cmlStat[6] <= 1'b1;
      if (strb.setUnsup) unsupFlag  <= 1'b1;
    end
  end

  // sequenced supply entries
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_MARG; i++) begin
        tonDly[i] <= '0;
        tonMax[i] <= TON_MAX_RST;
        seqCfg[i] <= '0;
      end
    end else if (strb.commit) begin
      for (int i = 0; i < NUM_MARG; i++) begin
        if (curPage == 8'(i)) begin
          case (curCode)
            CMD_TON_DLY: tonDly[i] <= wrData[15:0];
            CMD_TON_MAX: tonMax[i] <= wrData[15:0];
            CMD_SEQ_CFG: seqCfg[i] <= wrData;
            default: ;
          endcase
        end
      end
    end
  end

  // monitored channel entries
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_MON; i++) begin
        pgOn[i]  <= '0;
        vMin[i]  <= V_MIN_RST;
        chCfg[i] <= CH_CFG_RST;
      end
    end else if (strb.commit) begin
      for (int i = 0; i < NUM_MON; i++) begin
        if (curPage == 8'(i)) begin
          case (curCode)
            CMD_PG_ON:  pgOn[i]  <= wrData[15:0];
            CMD_V_MIN:  vMin[i]  <= wrData[15:0];
            CMD_CH_CFG: chCfg[i] <= wrData[15:0];
            default: ;
          endcase
        end
      end
    end
  end

  // temperature sensor entries and per-page operation byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_TEMP; i++) tPeak[i] <= '0;
      for (int i = 0; i < NUM_PAGES; i++) oper[i] <= OPER_RST;
    end else if (strb.commit) begin
      for (int i = 0; i < NUM_TEMP; i++) begin
        if (curCode == CMD_T_PEAK && curPage == 8'(NUM_MON + i))
          tPeak[i] <= wrData[15:0];
      end
      for (int i = 0; i < NUM_PAGES; i++) begin
        if (curCode == CMD_OPER && (curPage == 8'(i) || curPage == PAGE_ALL))
          oper[i] <= wrData[7:0];
      end
    end
  end

  // read word selection
  always_comb begin
    tempHit = (curPage >= 8'(NUM_MON)) && (curPage < 8'(NUM_PAGES));
    rdWord  = '0;
    case (curCode)
      CMD_PAGE:     rdWord = {24'd0, curPage};
      CMD_STAT_WRD: rdWord = {30'd0, |cmlStat, 1'b0};
      CMD_STAT_CML: rdWord = {24'd0, cmlStat};
      CMD_FW_REV:   rdWord = 32'd1;
      CMD_T_PEAK:   if (!tempHit) rdWord = {16'd0, tPeak[0]};
      default: ;
    endcase
    for (int i = 0; i < NUM_MARG; i++) begin
      if (curPage == 8'(i)) begin
        case (curCode)
          CMD_TON_DLY: rdWord = {16'd0, tonDly[i]};
          CMD_TON_MAX: rdWord = {16'd0, tonMax[i]};
          CMD_SEQ_CFG: rdWord = seqCfg[i];
          default: ;
        endcase
      end
    end
    for (int i = 0; i < NUM_MON; i++) begin
      if (curPage == 8'(i)) begin
        case (curCode)
          CMD_PG_ON:  rdWord = {16'd0, pgOn[i]};
          CMD_V_MIN:  rdWord = {16'd0, vMin[i]};
          CMD_CH_CFG: rdWord = {16'd0, chCfg[i]};
          default: ;
        endcase
      end
    end
    for (int i = 0; i < NUM_TEMP; i++) begin
      if (curCode == CMD_T_PEAK && curPage == 8'(NUM_MON + i))
        rdWord = {16'd0, tPeak[i]};
    end
    for (int i = 0; i < NUM_PAGES; i++) begin
      if (curCode == CMD_OPER && curPage == 8'(i)) rdWord = {24'd0, oper[i]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdByte  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.rdStrobe;
      if (strb.rdStrobe)
        rdByte <= strb.rdOk ? rdWord[{strb.rdIdx, 3'b000} +: 8] : 8'hFF;
    end
  end

endmodule

// File: rtl/pmbus_page_regs.sv
module pmbus_page_regs
  import pgreg_pkg::*;
#(
  parameter int NUM_MARG = 12,
  parameter int NUM_MON  = 16,
  parameter int NUM_TEMP = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrValid,
  input  logic [7:0] wrByte,
  input  logic       stopSeen,
  input  logic       rdReq,
  output logic [7:0] rdByte,
  output logic       rdValid,
  output logic       unsupFlag
);
  pgreg_strobe_t strb;
  logic [7:0]    curPage;
  logic [7:0]    curCode;
  logic [31:0]   wrData;

  pgreg_ctrl #(.NUM_MARG(NUM_MARG), .NUM_MON(NUM_MON), .NUM_TEMP(NUM_TEMP)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrByte(wrByte),
    .stopSeen(stopSeen), .rdReq(rdReq), .curPage(curPage),
    .curCode(curCode), .wrData(wrData), .strb(strb)
  );

  pgreg_data #(.NUM_MARG(NUM_MARG), .NUM_MON(NUM_MON), .NUM_TEMP(NUM_TEMP)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .curCode(curCode), .wrData(wrData),
    .curPage(curPage), .rdByte(rdByte), .rdValid(rdValid), .unsupFlag(unsupFlag)
  );

endmodule

// File: rtl/pgreg_chk.sv
module pgreg_chk (
  input logic       clk,
  input logic       rstN,
  input logic       stopSeen,
  input logic       rdReq,
  input logic [7:0] rdByte,
  input logic       rdValid,
  input logic       unsupFlag
);
  // R11
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !stopSeen) |=> rdValid);

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> (!rdValid && $stable(rdByte)));

  // R10
  unsup_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (unsupFlag && !stopSeen) |=> unsupFlag);

  // R8
  unsup_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!unsupFlag && !stopSeen && !rdReq) |=> !unsupFlag);
endmodule

bind pmbus_page_regs pgreg_chk u_pgregChk (
  .clk(clk), .rstN(rstN), .stopSeen(stopSeen), .rdReq(rdReq),
  .rdByte(rdByte), .rdValid(rdValid), .unsupFlag(unsupFlag)
);

// File: tb/pmbus_page_regs_test.sv
`timescale 1ns/1ps
module pmbus_page_regs_test;
  localparam logic [7:0] C_PAGE = 8'h00, C_OPER = 8'h01, C_CLR = 8'h03,
    C_PGON = 8'h5E, C_TON = 8'h60, C_TMAX = 8'h62, C_STW = 8'h79,
    C_STC = 8'h7E, C_CHC = 8'hD0, C_VMIN = 8'hD3, C_TPK = 8'hD5,
    C_SEQ = 8'hD8, C_IAVG = 8'hDA, C_FLOG = 8'hDB, C_FW = 8'hDC;

  logic clk = 1'b0, rstN = 1'b0, wrValid = 1'b0, stopSeen = 1'b0, rdReq = 1'b0;
  logic [7:0] wrByte = 8'd0;
  logic [7:0] rdByte;
  logic rdValid, unsupFlag;
  int nChk = 0, nFail = 0;
  bit done = 1'b0;

  // reference model
  logic [15:0] mTon [12], mTmax [12], mPg [16], mVmin [16], mCh [16], mTp [5];
  logic [31:0] mSeq [12];
  logic [7:0]  mOp [21];
  logic [7:0]  mPage, mCml;
  bit          mUns;

  always #10 clk = ~clk;

  pmbus_page_regs uut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrByte(wrByte),
    .stopSeen(stopSeen), .rdReq(rdReq), .rdByte(rdByte),
    .rdValid(rdValid), .unsupFlag(unsupFlag)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); wrValid = 1'b1; wrByte = b;
    @(negedge clk); wrValid = 1'b0;
  endtask

  task automatic endTxn();
    @(negedge clk); stopSeen = 1'b1;
    @(negedge clk); stopSeen = 1'b0;
  endtask

  task automatic writeCmd(input logic [7:0] c, input logic [31:0] v, input int n);
    sendByte(c);
    for (int k = 0; k < n; k++) sendByte(v[8*k +: 8]);
    endTxn();
  endtask

  task automatic readCmd(input logic [7:0] c, input int n, output logic [31:0] v);
    v = '1;
    sendByte(c);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); rdReq = 1'b1;
      @(negedge clk); rdReq = 1'b0;
      v[8*k +: 8] = rdByte;
    end
    endTxn();
  endtask

  task automatic setPage(input logic [7:0] p);
    writeCmd(C_PAGE, {24'd0, p}, 1);
  endtask

  function automatic int lenOf(input logic [7:0] c);
    case (c)
      C_PAGE, C_OPER, C_STC: return 1;
      C_PGON, C_TON, C_TMAX, C_STW, C_CHC, C_VMIN, C_TPK, C_IAVG, C_FW: return 2;
      C_SEQ, C_FLOG: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic bit isRo(input logic [7:0] c);
    return c == C_IAVG || c == C_FLOG || c == C_FW;
  endfunction

  function automatic bit legalW(input logic [7:0] c, input logic [7:0] p);
    case (c)
      C_PAGE: return 1;
      C_OPER: return p < 21 || p == 8'hFF;
      C_TON, C_TMAX, C_SEQ: return p < 12;
      C_PGON, C_VMIN, C_CHC: return p < 16;
      C_TPK: return p >= 16 && p < 21;
      default: return 0;
    endcase
  endfunction

  function automatic bit legalR(input logic [7:0] c, input logic [7:0] p);
    case (c)
      C_PAGE, C_STW, C_STC, C_FLOG, C_TPK: return 1;
      C_OPER: return p < 21;
      C_TON, C_TMAX, C_SEQ: return p < 12;
      C_PGON, C_VMIN, C_CHC, C_IAVG: return p < 16;
      C_FW: return p == 8'hFF;
      default: return 0;
    endcase
  endfunction

  function automatic string tagOf(input logic [7:0] c);
    case (c)
      C_TON, C_TMAX, C_SEQ: return "R3";
      C_PGON, C_VMIN, C_CHC, C_IAVG: return "R4";
      C_TPK: return "R5";
      C_FLOG: return "R6";
      C_FW: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic modelWrite(input logic [7:0] c, input logic [7:0] p,
                            input logic [31:0] v, input int n);
    if (n == lenOf(c) && lenOf(c) > 0 && legalW(c, p)) begin
      case (c)
        C_TON:  mTon[p]  = v[15:0];
        C_TMAX: mTmax[p] = v[15:0];
        C_SEQ:  mSeq[p]  = v;
        C_PGON: mPg[p]   = v[15:0];
        C_VMIN: mVmin[p] = v[15:0];
        C_CHC:  mCh[p]   = v[15:0];
        C_TPK:  mTp[p - 16] = v[15:0];
        C_OPER: if (p == 8'hFF) begin
                  for (int i = 0; i < 21; i++) mOp[i] = v[7:0];
                end else mOp[p] = v[7:0];
        C_PAGE: mPage = v[7:0];
        default: ;
      endcase
    end
    if (n >= 1) begin
      if (isRo(c)) mCml[6] = 1'b1;
      else if (!legalW(c, p)) mUns = 1'b1;
    end
  endtask

  function automatic logic [31:0] expRead(input logic [7:0] c, input logic [7:0] p);
    logic [31:0] val = '0;
    logic [31:0] r = '1;
    if (!legalR(c, p)) return r;
    case (c)
      C_TON:  val = {16'd0, mTon[p]};
      C_TMAX: val = {16'd0, mTmax[p]};
      C_SEQ:  val = mSeq[p];
      C_PGON: val = {16'd0, mPg[p]};
      C_VMIN: val = {16'd0, mVmin[p]};
      C_CHC:  val = {16'd0, mCh[p]};
      C_TPK:  val = (p >= 16 && p < 21) ? {16'd0, mTp[p - 16]} : {16'd0, mTp[0]};
      C_OPER: val = {24'd0, mOp[p]};
      C_FW:   val = 32'd1;
      default: val = '0;
    endcase
    for (int k = 0; k < lenOf(c); k++) r[8*k +: 8] = val[8*k +: 8];
    return r;
  endfunction

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] got;
    logic [7:0]  held;
    logic [7:0]  cmds [11];
    logic [7:0]  pages [11];
    int seed;
    seed = $urandom(32'd20240611);
    cmds  = '{C_TON, C_TMAX, C_SEQ, C_PGON, C_VMIN, C_CHC, C_TPK, C_OPER, C_IAVG, C_FLOG, C_FW};
    pages = '{8'd0, 8'd5, 8'd11, 8'd12, 8'd15, 8'd16, 8'd18, 8'd20, 8'd21, 8'd100, 8'hFF};
    for (int i = 0; i < 12; i++) begin mTon[i] = 0; mTmax[i] = 16'hFFFF; mSeq[i] = 0; end
    for (int i = 0; i < 16; i++) begin mPg[i] = 0; mVmin[i] = 16'h7FFF; mCh[i] = 16'h0020; end
    for (int i = 0; i < 5; i++) mTp[i] = 0;
    for (int i = 0; i < 21; i++) mOp[i] = 8'h80;
    mPage = 0; mCml = 0; mUns = 0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 unsup after reset", {31'd0, unsupFlag}, 32'd0);
    readCmd(C_PAGE, 1, got);  check("R1 page", got, 32'hFFFFFF00);
    readCmd(C_OPER, 1, got);  check("R1 oper page0", got, 32'hFFFFFF80);
    readCmd(C_STC, 1, got);   check("R1 status cml", got, 32'hFFFFFF00);
    setPage(8'd3);
    readCmd(C_TMAX, 2, got);  check("R1 ton max", got, 32'hFFFFFFFF);
    setPage(8'd15);
    readCmd(C_CHC, 2, got);   check("R1 chan cfg", got, 32'hFFFF0020);
    readCmd(C_VMIN, 2, got);  check("R1 vmin", got, 32'hFFFF7FFF);
    setPage(8'd20);
    readCmd(C_OPER, 1, got);  check("R1 oper page20", got, 32'hFFFFFF80);

    // R11 read timing
    sendByte(C_PAGE);
    @(negedge clk); rdReq = 1'b1;
    @(negedge clk); rdReq = 1'b0;
    check("R11 valid after strobe", {31'd0, rdValid}, 32'd1);
    held = rdByte;
    @(negedge clk);
    check("R11 valid drops", {31'd0, rdValid}, 32'd0);
    check("R11 byte holds", {24'd0, rdByte}, {24'd0, held});
    endTxn();

    // R2 byte ordering and count
    setPage(8'd2);
    writeCmd(C_TON, 32'h0000BEEF, 2);
    readCmd(C_TON, 2, got);   check("R2 lsb first", got, 32'hFFFFBEEF);
    writeCmd(C_TON, 32'h00123456, 3);
    readCmd(C_TON, 2, got);   check("R2 long write ignored", got, 32'hFFFFBEEF);
    writeCmd(C_TON, 32'h00000011, 1);
    readCmd(C_TON, 2, got);   check("R2 short write ignored", got, 32'hFFFFBEEF);
    writeCmd(C_SEQ, 32'hA1B2C3D4, 4);
    readCmd(C_SEQ, 4, got);   check("R2 32-bit value", got, 32'hA1B2C3D4);

    // R3 window
    setPage(8'd12);
    writeCmd(C_TON, 32'h00001111, 2);
    check("R3 write page12 flagged", {31'd0, unsupFlag}, 32'd1);
    writeCmd(C_CLR, 32'd0, 0);
    check("R10 clear", {31'd0, unsupFlag}, 32'd0);
    readCmd(C_TON, 2, got);   check("R3 read page12", got, 32'hFFFFFFFF);
    check("R8 illegal read flagged", {31'd0, unsupFlag}, 32'd1);
    writeCmd(C_CLR, 32'd0, 0);

    // R4 window and average current
    setPage(8'd15);
    writeCmd(C_PGON, 32'h00004321, 2);
    readCmd(C_PGON, 2, got);  check("R4 pg on page15", got, 32'hFFFF4321);
    readCmd(C_IAVG, 2, got);  check("R4 avg current", got, 32'hFFFF0000);

    // R5 temperature index and fallback
    setPage(8'd17); writeCmd(C_TPK, 32'h00001234, 2);
    setPage(8'd16); writeCmd(C_TPK, 32'h00005678, 2);
    setPage(8'd17); readCmd(C_TPK, 2, got); check("R5 entry 1", got, 32'hFFFF1234);
    setPage(8'd3);  readCmd(C_TPK, 2, got); check("R5 fallback page3", got, 32'hFFFF5678);
    check("R5 fallback not flagged", {31'd0, unsupFlag}, 32'd0);
    writeCmd(C_TPK, 32'h00009999, 2);
    setPage(8'd16); readCmd(C_TPK, 2, got); check("R5 write off-window ignored", got, 32'hFFFF5678);
    writeCmd(C_CLR, 32'd0, 0);

    // R6 and R7 read-only commands
    setPage(8'hFF);
    writeCmd(C_FW, 32'h00000055, 2);
    readCmd(C_STC, 1, got);   check("R6 cml invalid data", got, 32'hFFFFFF40);
    readCmd(C_STW, 2, got);   check("R6 status word cml", got, 32'hFFFF0002);
    check("R6 no unsup", {31'd0, unsupFlag}, 32'd0);
    readCmd(C_FW, 2, got);    check("R7 fw rev page255", got, 32'hFFFF0001);
    setPage(8'd0);
    readCmd(C_FW, 2, got);    check("R7 fw rev page0", got, 32'hFFFFFFFF);
    writeCmd(C_CLR, 32'd0, 0);
    readCmd(C_STC, 1, got);   check("R10 cml cleared", got, 32'hFFFFFF00);

    // R8 read past length
    readCmd(C_PAGE, 2, got);  check("R8 past length", got, 32'hFFFFFF00);
    check("R8 past length not flagged", {31'd0, unsupFlag}, 32'd0);
    readCmd(8'h42, 1, got);   check("R8 unknown code", got, 32'hFFFFFFFF);
    writeCmd(C_CLR, 32'd0, 0);

    // R9 broadcast
    setPage(8'hFF);
    writeCmd(C_OPER, 32'h00000040, 1);
    readCmd(C_OPER, 1, got);  check("R9 read page255 illegal", got, 32'hFFFFFFFF);
    setPage(8'd7);  writeCmd(C_OPER, 32'h00000000, 1);
    readCmd(C_OPER, 1, got);  check("R9 single page", got, 32'hFFFFFF00);
    setPage(8'd8);  readCmd(C_OPER, 1, got); check("R9 broadcast page8", got, 32'hFFFFFF40);
    setPage(8'd20); readCmd(C_OPER, 1, got); check("R9 broadcast page20", got, 32'hFFFFFF40);
    writeCmd(C_CLR, 32'd0, 0);

    // sync model with directed writes
    mTon[2] = 16'hBEEF; mSeq[2] = 32'hA1B2C3D4; mPg[15] = 16'h4321;
    mTp[0] = 16'h5678; mTp[1] = 16'h1234;
    for (int i = 0; i < 21; i++) mOp[i] = 8'h40;
    mOp[7] = 8'h00; mCml = 0; mUns = 0;

    // constrained random
    for (int it = 0; it < 200; it++) begin
      logic [7:0]  c, p;
      logic [31:0] v;
      int n;
      c = cmds[$urandom_range(0, 10)];
      p = pages[$urandom_range(0, 10)];
      v = $urandom;
      n = lenOf(c);
      if ($urandom_range(0, 7) == 0) n = (n == 4) ? 1 : n + 1;
      setPage(p);
      writeCmd(c, v, n);
      modelWrite(c, p, v, n);
      readCmd(c, lenOf(c), got);
      check(tagOf(c), got, expRead(c, p));
      if (!legalR(c, p)) mUns = 1'b1;
      check("R8 flag tracking", {31'd0, unsupFlag}, {31'd0, mUns});
      if (it % 16 == 15) begin
        readCmd(C_STC, 1, got);
        check("R6 cml tracking", got, {24'hFFFFFF, mCml});
        writeCmd(C_CLR, 32'd0, 0);
        mCml = 0; mUns = 0;
      end
    end

    finishRun();
  end
endmodule